// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block watches a serial receive line and recovers asynchronous characters from it. Each character begins with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, then a high stop bit. The recovered character goes into a parallel receive buffer, and a ready flag tells the host that it is there. The framing setting is shared with the matching transmitter: character length, parity enable and sense, and the oversampling (baud) factor.

Timing comes from a receiver-clock strobe, `rxc_tick`. Every bit period lasts 1, 16 or 64 strobes, set by the baud factor. A low level seen while hunting does not commit the receiver to a character. It must still be low half a bit time later, otherwise the event is dropped as a glitch. From a valid start, the line is sampled once per bit time. The receiver checks parity, removes the stop bit and clears buffer bits above the character length. It reports parity, framing and overrun errors until the host clears them.

Top module: `serial_char_rx`

## Requirements
- R1: While `rx_en` is 0 the receiver stays in its hunting state and delivers no character: `rx_ready` does not rise.
- R2: At baud factors 16 and 64, a start bit is accepted only if the line is still low half a bit time (8 or 32 strobes) after the first low sample. A shorter low pulse is discarded, and the receiver then hunts for the next start bit.
- R3: Baud code 0 gives factor 1, code 1 gives factor 16, and codes 2 and 3 give factor 64. After a valid start, one sample is taken per bit time, and data bits are assembled least significant bit first.
- R4: Length code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. Buffer bits above the character length read as 0.
- R5: With `cfg_par_en` set, a parity bit follows the most significant data bit. Even sense (`cfg_par_odd`=0) expects an even count of ones over data plus parity, and odd sense expects an odd count. A mismatch sets `err_parity`.
- R6: A low level at the stop-bit sample sets `err_frame`. The character is still placed in the buffer.
- R7: `rx_ready` rises one cycle after a character is placed in the buffer. A one-cycle `host_rd` pulse clears it.
- R8: If a character arrives while `rx_ready` is still set and not being read, it overwrites the buffer and sets `err_overrun`.
- R9: An `err_clr` pulse clears `err_parity`, `err_frame` and `err_overrun`.
- R10: After reset, `rx_ready`, all error flags and `rx_data` are 0.
- R11: At factor 1 there is no half-bit check. A low sample starts a character, and each following strobe samples the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxc_tick | input | 1 | Receiver-clock strobe, one per oversampling step |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receive enable |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Parity sense, 1 = odd |
| cfg_baud | input | 2 | Baud factor code |
| host_rd | input | 1 | Host read pulse, clears ready |
| err_clr | input | 1 | Error flag clear pulse |
| rx_data | output | 8 | Receive buffer, zero-filled above length |
| rx_ready | output | 1 | Character available |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |

## Verification
At factor 16, characters are swept over every length code and every parity mode with spread data values. This separates wrong bit order, wrong length masking and wrong parity sense. All 256 eight-bit values are sent at factor 1, which exposes any half-bit delay wrongly kept at that factor. A few frames at factor 64 check that the timer reloads correctly. Short low pulses, bad parity, a low stop bit, two characters sent back to back without a read, and a frame sent with receive disabled each separate one error or gating path from normal delivery.

// File: rtl/rxs_pkg.sv
// Shared types and constants for the serial character receiver.
// Assumes characters of at most 8 data bits.
package rxs_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_t;

    // Baud factor codes
    localparam logic [1:0] BAUD_X1  = 2'd0;
    localparam logic [1:0] BAUD_X16 = 2'd1;
endpackage

// File: rtl/rxs_sync.sv
// Line synchronizer: brings the asynchronous receive line into the clock domain.
// Assumes the line idles high, so stages reset to 1.
module rxs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg;

    // Shift the line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '1;
        else        stg <= {stg[STAGES-2:0], din};
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/rxs_bit_timer.sv
// Bit timer: counts receiver strobes down to the next sample point.
// A load selects half-bit or full-bit reload for the configured factor.
// Assumes OVS_HIGH is the largest factor and both factors are even.
module rxs_bit_timer #(
    parameter int OVS_MID  = 16,
    parameter int OVS_HIGH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic       load_half,
    input  logic [1:0] baud,
    output logic       expire
);
    import rxs_pkg::*;
    localparam int CW = $clog2(OVS_HIGH);

    logic [CW-1:0] cnt, reload;

    // Pick the reload value from factor and half/full choice
    always_comb begin
        if (baud == BAUD_X1)
            reload = '0;
        else if (baud == BAUD_X16)
            reload = load_half ? CW'(OVS_MID/2 - 1)  : CW'(OVS_MID - 1);
        else
            reload = load_half ? CW'(OVS_HIGH/2 - 1) : CW'(OVS_HIGH - 1);
    end

    // Reload on request, otherwise count strobes down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= reload;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign expire = tick && (cnt == '0);
endmodule

// File: rtl/rxs_frame_fsm.sv
// Frame sequencer: validates the start bit, samples data, parity and stop,
// and presents the assembled character for one cycle on chr_done.
// Assumes the timer expire strobe marks each sample point.
module rxs_frame_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       tick,
    input  logic       rxd_s,
    input  logic       expire,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_baud,
    output logic       tmr_load,
    output logic       tmr_half,
    output logic       chr_done,
    output logic [7:0] chr_data,
    output logic       chr_perr,
    output logic       chr_ferr
);
    import rxs_pkg::*;

    rx_state_t  state;
    logic [7:0] shreg;
    logic [2:0] bitcnt;
    logic       par_bad;
    logic       start_seen;

    assign start_seen = (state == ST_HUNT) && tick && !rxd_s;

    // Align the collected bits down to bit 0, zero-filling the top
    assign chr_data = shreg >> (2'd3 - cfg_len);

    // Timer reloads on a new start and at every sample point except the stop
    assign tmr_load = rx_en && (start_seen || (expire && state != ST_HUNT && state != ST_STOP));
    assign tmr_half = (state == ST_HUNT);

    assign chr_done = rx_en && (state == ST_STOP) && expire;
    assign chr_perr = par_bad;
    assign chr_ferr = !rxd_s;

    // Frame state progression and bit collection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            shreg   <= '0;
            bitcnt  <= '0;
            par_bad <= 1'b0;
        end else if (!rx_en) begin
            state <= ST_HUNT;
        end else begin
            case (state)
                ST_HUNT: if (start_seen) begin
                    state   <= (cfg_baud == BAUD_X1) ? ST_DATA : ST_START;
                    bitcnt  <= '0;
                    par_bad <= 1'b0;
                end
                ST_START: if (expire) begin
                    state <= rxd_s ? ST_HUNT : ST_DATA;
                end
                ST_DATA: if (expire) begin
                    shreg <= {rxd_s, shreg[7:1]};
                    if (bitcnt == {1'b1, cfg_len}) begin
                        state <= cfg_par_en ? ST_PAR : ST_STOP;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_PAR: if (expire) begin
                    par_bad <= ((^chr_data) ^ rxd_s) != cfg_par_odd;
                    state   <= ST_STOP;
                end
                ST_STOP: if (expire) begin
                    state <= ST_HUNT;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/rxs_rx_buffer.sv
// Receive buffer and host-visible flags: holds the last character,
// raises ready, and keeps sticky parity, framing and overrun errors.
// Assumes host_rd and err_clr are single-cycle pulses.
module rxs_rx_buffer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       perr_in,
    input  logic       ferr_in,
    input  logic       host_rd,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);
    // Capture characters and maintain ready and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (load) rx_data <= din;
            rx_ready    <= load || (rx_ready && !host_rd);
            err_parity  <= (err_parity && !err_clr) || (load && perr_in);
            err_frame   <= (err_frame && !err_clr) || (load && ferr_in);
            err_overrun <= (err_overrun && !err_clr) || (load && rx_ready && !host_rd);
        end
    end
endmodule

// File: rtl/serial_char_rx.sv
// Top of the asynchronous serial character receiver.
// Chains synchronizer, bit timer, frame sequencer and receive buffer.
// Assumes rxc_tick is a one-cycle strobe at the receiver clock rate.
module serial_char_rx #(
    parameter int OVS_MID     = 16,
    parameter int OVS_HIGH    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxc_tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_baud,
    input  logic       host_rd,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);
    logic       rxd_s, expire, tmr_load, tmr_half;
    logic       chr_done, chr_perr, chr_ferr;
    logic [7:0] chr_data;

    rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    rxs_bit_timer #(.OVS_MID(OVS_MID), .OVS_HIGH(OVS_HIGH)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(rxc_tick), .load(tmr_load),
        .load_half(tmr_half), .baud(cfg_baud), .expire(expire)
    );

    rxs_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(rxc_tick),
        .rxd_s(rxd_s), .expire(expire), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_baud(cfg_baud), .tmr_load(tmr_load), .tmr_half(tmr_half),
        .chr_done(chr_done), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr)
    );

    rxs_rx_buffer u_buf (
        .clk(clk), .rst_n(rst_n), .load(chr_done), .din(chr_data),
        .perr_in(chr_perr), .ferr_in(chr_ferr), .host_rd(host_rd),
        .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );
endmodule

// File: rtl/rxs_checker.sv
// Property checker for the serial character receiver, bound to the top.
module rxs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic [1:0] cfg_len,
    input logic       host_rd,
    input logic       err_clr,
    input logic       chr_done,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_overrun
);
    assert_no_ready_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && $past(!rx_en) && !rx_ready) |=> !rx_ready);

    assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_ready) && cfg_len == 2'd0) |-> rx_data[7:5] == 3'b000);

    assert_ready_from_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(chr_done));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !chr_done) |=> !rx_ready);

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_done && rx_ready && !host_rd) |=> err_overrun);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !chr_done) |=> (!err_parity && !err_frame && !err_overrun));
endmodule

bind serial_char_rx rxs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_len(cfg_len),
    .host_rd(host_rd), .err_clr(err_clr), .chr_done(chr_done),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/serial_char_rx_bench.sv
module serial_char_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxc_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_baud = 2'd1;
    logic       host_rd = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_frame, err_overrun;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    serial_char_rx u_serial_char_rx (
        .clk(clk), .rst_n(rst_n), .rxc_tick(rxc_tick), .rxd(rxd),
        .rx_en(rx_en), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_baud(cfg_baud), .host_rd(host_rd),
        .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int factor_of(input logic [1:0] code);
        if (code == 2'd0) return 1;
        if (code == 2'd1) return 16;
        return 64;
    endfunction

    task automatic drive_bit(input logic b, input int fac);
        @(negedge clk);
        rxd = b;
        repeat (fac - 1) @(negedge clk);
    endtask

    // Send one frame with the current configuration; optional faults
    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        int fac = factor_of(cfg_baud);
        int nb = 5 + int'(cfg_len);
        logic p = 1'b0;
        drive_bit(1'b0, fac);
        for (int i = 0; i < nb; i++) begin
            drive_bit(d[i], fac);
            p ^= d[i];
        end
        if (cfg_par_en) drive_bit(p ^ cfg_par_odd ^ bad_par, fac);
        drive_bit(!bad_stop, fac);
        @(negedge clk);
        rxd = 1'b1;
        repeat (bad_stop ? 2 * fac + 4 : 4) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    function automatic logic [7:0] masked(input logic [7:0] d, input logic [1:0] len);
        return d & (8'hFF >> (2'd3 - len));
    endfunction

    // Send a clean frame, check delivery, then read it out
    task automatic round_trip(input logic [7:0] d, input string req);
        send(d, 1'b0, 1'b0);
        check({req, " ready"}, rx_ready, 1'b1);
        check({req, " data"}, rx_data, masked(d, cfg_len));
        check({req, " no perr"}, err_parity, 1'b0);
        check({req, " no ferr"}, err_frame, 1'b0);
        pulse_rd();
        check("R7 read clears ready", rx_ready, 1'b0);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 ready", rx_ready, 1'b0);
        check("R10 data", rx_data, 8'h00);
        check("R10 errors", {err_parity, err_frame, err_overrun}, 3'b000);

        // R3 R4 R5: factor 16 sweep over lengths and parity modes
        cfg_baud = 2'd1;
        for (int cl = 0; cl < 4; cl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                cfg_len = 2'(cl);
                cfg_par_en = (pm != 0);
                cfg_par_odd = (pm == 2);
                for (int k = 0; k < 8; k++) begin
                    round_trip(8'(k * 37 + cl * 11 + pm * 90 + 5), "R3 R4 R5 x16");
                end
            end
        end

        // R11 factor 1: all eight-bit values, no parity
        cfg_baud = 2'd0; cfg_len = 2'd3; cfg_par_en = 1'b0;
        for (int v = 0; v < 256; v++) round_trip(8'(v), "R11 x1");

        // R3 factor 64, both codes
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        cfg_baud = 2'd2;
        round_trip(8'h5A, "R3 x64 code2");
        round_trip(8'h23, "R3 x64 code2");
        cfg_baud = 2'd3;
        round_trip(8'h7F, "R3 x64 code3");

        // R2 glitch rejection at factor 16 and 64
        cfg_baud = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0;
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        check("R2 glitch x16 ignored", rx_ready, 1'b0);
        round_trip(8'hC3, "R2 recovery");
        cfg_baud = 2'd2;
        @(negedge clk); rxd = 1'b0;
        repeat (20) @(negedge clk);
        rxd = 1'b1;
        repeat (800) @(negedge clk);
        check("R2 glitch x64 ignored", rx_ready, 1'b0);
        cfg_baud = 2'd1;

        // R5 parity error, then R9 clear
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'h96, 1'b1, 1'b0);
        check("R5 perr", err_parity, 1'b1);
        check("R5 data kept", rx_data, 8'h96);
        pulse_rd();
        pulse_clr();
        check("R9 perr cleared", err_parity, 1'b0);

        // R6 framing error
        cfg_par_en = 1'b0;
        send(8'h3C, 1'b0, 1'b1);
        check("R6 ferr", err_frame, 1'b1);
        check("R6 ready", rx_ready, 1'b1);
        check("R6 data", rx_data, 8'h3C);
        pulse_rd();
        pulse_clr();
        check("R9 ferr cleared", err_frame, 1'b0);

        // R8 overrun
        send(8'h11, 1'b0, 1'b0);
        check("R8 no overrun yet", err_overrun, 1'b0);
        send(8'hE4, 1'b0, 1'b0);
        check("R8 overrun", err_overrun, 1'b1);
        check("R8 overwritten", rx_data, 8'hE4);
        check("R8 ready", rx_ready, 1'b1);
        pulse_rd();
        pulse_clr();
        check("R9 overrun cleared", err_overrun, 1'b0);

        // R1 receive disabled
        rx_en = 1'b0;
        send(8'hA5, 1'b0, 1'b0);
        check("R1 disabled no ready", rx_ready, 1'b0);
        check("R1 disabled data held", rx_data, 8'hE4);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        round_trip(8'h5B, "R1 re-enabled");

        finish_run();
    end
endmodule